// File: doc/BRIEF.md
# Complementary Buzzer Pin Multiplexer

This block owns two general-purpose port pins, pin A (index 0) and pin B (index 1). Each pin can be a plain input, a CMOS output that drives its data register bit, or a buzzer output that carries a tone supplied by an external timer. Software sets a direction register and a data register through a single-cycle write strobe. Two buzzer-mode selection inputs choose the buzzer function for each pin. The block drives a pad output value and an output enable for each pin. A registered read port returns the direction register, the data register or the synchronised pad levels.

Pin A's buzzer output carries the tone when its data bit is 1 and holds 0 when the bit is 0. Pin B behaves differently. Its buzzer output only works as the second half of a pair: both pins must be outputs and both must be in buzzer mode. In that state pin B carries the inverted tone, gated by pin A's data bit, and its own data bit has no effect. The two pins can then drive a piezo element differentially. Enabling or silencing the pair takes one data-register write.

Top module: `bzmux_top`

## Requirements
- R1: While reset is active, and right after it, both output enables are 0 and both pad outputs are 0. The direction and data registers both read back 0, and both buzzer modes are off.
- R2: A write with `wr_sel`=0 loads the direction register. Bit 0 belongs to pin A and bit 1 to pin B, and 1 means output. `pad_oe` equals the written value from the clock edge that accepts the write.
- R3: A pin that is an output and not in an active buzzer mode drives its own data register bit. A write with `wr_sel`=1 loads the data register, with the same bit order as the direction register.
- R4: A pin whose direction bit is 0 has output enable 0 and pad output 0, whatever its buzzer-mode selection or data bit.
- R5: When pin A is an output with `bz_mode_a`=1, its pad output equals `tone` while data bit 0 is 1, and equals 0 while data bit 0 is 0.
- R6: When both pins are outputs and both buzzer modes are 1, pin B's pad output is the inverse of `tone` while data bit 0 is 1, and 0 while data bit 0 is 0. Data bit 1 has no effect in this state.
- R7: Pin B's buzzer selection takes effect only in the pair state of R6. Otherwise pin B is an ordinary input or CMOS output, and this holds while pin A is in buzzer mode.
- R8: The read port is registered. `rd_sel` 0 returns the direction register, 1 the data register, 2 the synchronised pad levels and 3 returns 0. `rd_data` changes only on an edge where `rd_en` is 1.
- R9: Pad levels pass through a two-flop synchronizer. A change on `pad_in` appears in `rd_data` on the third clock edge after the change when `rd_en`=1 with `rd_sel`=2 on that edge. Earlier reads return the previous level.
- R10: The buzzer-mode selection inputs are registered. A change is seen at the pads from the clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 direction, 1 data |
| wr_data | input | 2 | Write value, bit 0 pin A, bit 1 pin B |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 2 | Read source: 0 direction, 1 data, 2 pads, 3 zero |
| rd_data | output | 2 | Registered read result |
| bz_mode_a | input | 1 | Buzzer-mode selection for pin A |
| bz_mode_b | input | 1 | Buzzer-mode selection for pin B |
| tone | input | 1 | Free-running buzzer tone |
| pad_in | input | 2 | Pad input levels |
| pad_out | output | 2 | Pad output values |
| pad_oe | output | 2 | Pad output enables |

## Verification
The pads follow `tone` within the same cycle. They follow a direction or data write from the accepting edge, and a buzzer-mode change from the edge after it is applied. The read data changes on the edge of the strobe, and a pad change appears on the third edge. The bench drives every input on the falling edge and samples on the next falling edge after the edges that matter. The synchroniser test strobes a read on each of three consecutive edges and expects the old level twice and the new level on the third.

// File: rtl/bzmux_pkg.sv
package bzmux_pkg;
  localparam int NPIN = 2;

  typedef enum logic {
    WSEL_DIR  = 1'b0,
    WSEL_DATA = 1'b1
  } wsel_e;

  typedef enum logic [1:0] {
    RSEL_DIR  = 2'd0,
    RSEL_DATA = 2'd1,
    RSEL_PAD  = 2'd2,
    RSEL_ZERO = 2'd3
  } rsel_e;

  // Pin A: tone gated by its own data bit in buzzer mode, else the data bit
  function automatic logic pin_a_level(input logic buzz, input logic dat_a,
                                       input logic tone_i);
    return buzz ? (dat_a & tone_i) : dat_a;
  endfunction

  // Pin B: inverted tone gated by pin A's data bit while paired
  function automatic logic pin_b_level(input logic paired, input logic dat_a,
                                       input logic dat_b, input logic tone_i);
    return paired ? (dat_a & ~tone_i) : dat_b;
  endfunction
endpackage

// File: rtl/bzmux_regs.sv
module bzmux_regs
  import bzmux_pkg::*;
#(
  parameter int W = NPIN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic [1:0]   rd_sel,
  input  logic [W-1:0] pad_sync,
  input  logic [W-1:0] mode_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q,
  output logic [W-1:0] mode_q,
  output logic [W-1:0] rd_q
);
  logic         wr_dir, wr_dat;
  logic [W-1:0] rd_mux;

  assign wr_dir = wr_en && (wsel_e'(wr_sel) == WSEL_DIR);
  assign wr_dat = wr_en && (wsel_e'(wr_sel) == WSEL_DATA);

  always_comb begin
    unique case (rsel_e'(rd_sel))
      RSEL_DIR:  rd_mux = dir_q;
      RSEL_DATA: rd_mux = data_q;
      RSEL_PAD:  rd_mux = pad_sync;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
      mode_q <= '0;
      rd_q   <= '0;
    end else begin
      mode_q <= mode_in;
      if (wr_dir) dir_q  <= wr_data;
      if (wr_dat) data_q <= wr_data;
      if (rd_en)  rd_q   <= rd_mux;
    end
  end
endmodule

// File: rtl/bzmux_insync.sv
module bzmux_insync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/bzmux_padmux.sv
module bzmux_padmux
  import bzmux_pkg::*;
(
  input  logic [1:0] dir_q,
  input  logic [1:0] data_q,
  input  logic [1:0] mode_q,
  input  logic       tone,
  output logic       a_buzz,
  output logic       paired,
  output logic [1:0] out_o,
  output logic [1:0] oe_o
);
  assign a_buzz = dir_q[0] & mode_q[0];
  assign paired = a_buzz & dir_q[1] & mode_q[1];
  assign oe_o   = dir_q;

  always_comb begin
    out_o[0] = dir_q[0] & pin_a_level(a_buzz, data_q[0], tone);
    out_o[1] = dir_q[1] & pin_b_level(paired, data_q[0], data_q[1], tone);
  end
endmodule

// File: rtl/bzmux_top.sv
module bzmux_top
  import bzmux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [1:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_sel,
  output logic [1:0] rd_data,
  input  logic       bz_mode_a,
  input  logic       bz_mode_b,
  input  logic       tone,
  input  logic [1:0] pad_in,
  output logic [1:0] pad_out,
  output logic [1:0] pad_oe
);
  logic [1:0] dir_q, data_q, mode_q, pad_sync;
  logic       a_buzz_active, pair_active;

  bzmux_insync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_sync)
  );

  bzmux_regs #(.W(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel),
    .pad_sync(pad_sync), .mode_in({bz_mode_b, bz_mode_a}),
    .dir_q(dir_q), .data_q(data_q), .mode_q(mode_q), .rd_q(rd_data)
  );

  bzmux_padmux u_mux (
    .dir_q(dir_q), .data_q(data_q), .mode_q(mode_q), .tone(tone),
    .a_buzz(a_buzz_active), .paired(pair_active),
    .out_o(pad_out), .oe_o(pad_oe)
  );
endmodule

// File: rtl/bzmux_chk.sv
module bzmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [1:0] wr_data,
  input logic       rd_en,
  input logic [1:0] rd_data,
  input logic [1:0] pad_out,
  input logic [1:0] pad_oe,
  input logic       a_buzz_active,
  input logic       pair_active,
  input logic       data_a
);
  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (pad_oe == 2'b00 && pad_out == 2'b00);
  end

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (pad_oe == $past(wr_data)));

  // R4
  input_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == 2'b00));

  // R5
  a_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_buzz_active && !data_a) |-> (pad_out[0] == 1'b0));

  // R6
  pair_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_active && data_a) |-> (pad_out[1] == !pad_out[0]));

  // R6
  pair_muted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_active && !data_a) |-> (pad_out == 2'b00));

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind bzmux_top bzmux_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
  .pad_out(pad_out), .pad_oe(pad_oe), .a_buzz_active(a_buzz_active),
  .pair_active(pair_active), .data_a(data_q[0])
);

// File: tb/tb_bzmux_top.sv
module tb_bzmux_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0;
  logic [1:0] wr_data = '0, rd_sel = '0, pad_in = '0;
  logic       bz_mode_a = 1'b0, bz_mode_b = 1'b0, tone = 1'b0;
  logic [1:0] rd_data, pad_out, pad_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bzmux_top dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
    .bz_mode_a(bz_mode_a), .bz_mode_b(bz_mode_b), .tone(tone),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // {dir[1:0], data[1:0], mode_b, mode_a, tone, exp_oe[1:0], exp_out[1:0]}
  localparam int NV = 13;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 2'b11, 2'b11, 1'b1, 2'b00, 2'b00},  // R4 inputs ignore mode
    {2'b01, 2'b01, 2'b00, 1'b1, 2'b01, 2'b01},  // R3
    {2'b11, 2'b10, 2'b00, 1'b0, 2'b11, 2'b10},  // R3
    {2'b01, 2'b01, 2'b01, 1'b1, 2'b01, 2'b01},  // R5 tone high
    {2'b01, 2'b01, 2'b01, 1'b0, 2'b01, 2'b00},  // R5 tone low
    {2'b01, 2'b00, 2'b01, 1'b1, 2'b01, 2'b00},  // R5 muted
    {2'b11, 2'b10, 2'b01, 1'b1, 2'b11, 2'b10},  // R7 B plain CMOS
    {2'b11, 2'b01, 2'b11, 1'b1, 2'b11, 2'b01},  // R6
    {2'b11, 2'b01, 2'b11, 1'b0, 2'b11, 2'b10},  // R6
    {2'b11, 2'b10, 2'b11, 1'b1, 2'b11, 2'b00},  // R6 B data ignored
    {2'b10, 2'b10, 2'b11, 1'b0, 2'b10, 2'b10},  // R7 A input, no pair
    {2'b11, 2'b11, 2'b10, 1'b0, 2'b11, 2'b11},  // R7 B mode alone
    {2'b11, 2'b11, 2'b11, 1'b0, 2'b11, 2'b10}   // R6
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [1:0] v);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] sel);
    rd_en = 1'b1; rd_sel = sel;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe/out in reset", {pad_oe, pad_out}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe/out after reset", {pad_oe, pad_out}, 4'b0000);
    do_read(2'd0);
    check("R1 dir reads 0", {2'b00, rd_data}, 4'b0000);
    do_read(2'd1);
    check("R1 data reads 0", {2'b00, rd_data}, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      bz_mode_b = VEC[i][6];
      bz_mode_a = VEC[i][5];
      tone      = VEC[i][4];
      do_write(1'b0, VEC[i][10:9]);
      do_write(1'b1, VEC[i][8:7]);
      check($sformatf("R3-R7 vector %0d", i), {pad_oe, pad_out}, VEC[i][3:0]);
    end

    // R2: oe follows from the accepting edge
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 2'b01;
    @(posedge clk); #1;
    check("R2 oe at write edge", {2'b00, pad_oe}, 4'b0001);
    @(negedge clk); wr_en = 1'b0;

    // R8: read back and hold
    do_write(1'b1, 2'b10);
    do_read(2'd1);
    check("R8 data readback", {2'b00, rd_data}, 4'b0010);
    do_write(1'b1, 2'b01);
    @(negedge clk);
    check("R8 held without strobe", {2'b00, rd_data}, 4'b0010);
    do_read(2'd3);
    check("R8 select 3 reads 0", {2'b00, rd_data}, 4'b0000);

    // R10: mode change seen one edge later (dir 01, data 01, tone 0)
    tone = 1'b0; bz_mode_b = 1'b0; bz_mode_a = 1'b0;
    @(negedge clk);
    bz_mode_a = 1'b1;
    #1 check("R10 before edge", {2'b00, pad_out}, 4'b0001);
    @(negedge clk);
    check("R10 after edge", {2'b00, pad_out}, 4'b0000);

    // R9: synchroniser latency
    pad_in = 2'b00;
    do_read(2'd2); do_read(2'd2); do_read(2'd2);
    pad_in = 2'b10;
    rd_en = 1'b1; rd_sel = 2'd2;
    @(posedge clk); @(negedge clk);
    check("R9 edge 1 old", {2'b00, rd_data}, 4'b0000);
    @(posedge clk); @(negedge clk);
    check("R9 edge 2 old", {2'b00, rd_data}, 4'b0000);
    @(posedge clk); @(negedge clk);
    check("R9 edge 3 new", {2'b00, rd_data}, 4'b0010);
    rd_en = 1'b0;

    // R1: reset in mid-run
    do_write(1'b0, 2'b11);
    do_write(1'b1, 2'b11);
    rst_n = 1'b0;
    #1 check("R1 async reset clears pads", {pad_oe, pad_out}, 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    bz_mode_a = 1'b0;
    @(negedge clk);
    do_read(2'd0);
    check("R1 dir cleared", {2'b00, rd_data}, 4'b0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule